// File: doc/BRIEF.md
# Circular Event Queue Writer

This block appends one 32-bit event word to a circular queue that lives in external memory. Each request arrives with a per-queue descriptor: the queue base address, a size code, the current write index, the current generation bit and the stored generation-flipped flag. From these the block builds the entry and its address, and issues exactly one write on a valid/ready memory port.

Once the memory acknowledges, the block returns the descriptor fields to be written back for one cycle. On success the index advances modulo the queue length. When the index wraps to zero, the generation bit inverts. Consumers compare the top bit of each entry with the generation they expect, which lets them separate fresh entries from stale ones without sharing a pointer with the producer.

Only one write may be outstanding at a time. The block reports itself busy from the cycle after it accepts a request until the update has been handed back.

Top module: `evq_writer`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `mem_valid` and `upd_valid` are low.
- R2: A request with `req_valid` high while `busy` is low is accepted. In the next cycle `busy` and `mem_valid` are high. A request presented while `busy` is high is ignored: it causes no second write and no second update.
- R3: `mem_addr` equals the base address plus four times the index, modulo 2^ADDR_W. Before use, the index is reduced modulo the queue length.
- R4: The entry holds the generation bit at bit 31 and the 31 event data bits at bits 30:0. It is driven in big-endian byte order: `mem_wdata[7:0]` carries entry bits 31:24, `mem_wdata[15:8]` bits 23:16, `mem_wdata[23:16]` bits 15:8 and `mem_wdata[31:24]` bits 7:0.
- R5: The queue holds 2^(size code + 10) entries. A size code above MAX_CODE (default 6) is treated as MAX_CODE.
- R6: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` hold their values.
- R7: In the cycle after `mem_valid` and `mem_ready` are both high, `upd_valid` is high for exactly one cycle. In the cycle after that, `busy` is low.
- R8: After a successful write that does not wrap, `upd_index` is the reduced index plus one, and `upd_gen`, `upd_gen_flip` equal the request's generation and flip flag, with `upd_err` low.
- R9: After a successful write whose incremented index wraps to zero, `upd_index` is 0, `upd_gen` is the inverted generation, and `upd_gen_flip` equals that new generation.
- R10: If `mem_err` is high with `mem_ready`, then `upd_err` is high and `upd_index`, `upd_gen`, `upd_gen_flip` return the reduced index, generation and flip flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Enqueue request |
| req_data | input | 31 | Event data bits placed below the generation bit |
| req_base | input | ADDR_W | Queue base byte address |
| req_size | input | SIZE_W | Size code; entries = 2^(code+10) |
| req_index | input | IDX_W | Current write index |
| req_gen | input | 1 | Current generation bit |
| req_gen_flip | input | 1 | Stored generation-flipped flag |
| busy | output | 1 | A request is in progress; new requests are refused |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Entry in big-endian byte order |
| mem_ready | input | 1 | Memory accepts the write |
| mem_err | input | 1 | Write failed; sampled with mem_ready |
| upd_valid | output | 1 | Descriptor update strobe, one cycle |
| upd_index | output | IDX_W | Index to store back |
| upd_gen | output | 1 | Generation bit to store back |
| upd_gen_flip | output | 1 | Generation-flipped flag to store back |
| upd_err | output | 1 | The write reported an error |

## Verification
The main path is driven with random data, bases, indices, size codes across the full code range and memory response delays. These separate the mid-queue increment from the wrap, and clamped size codes from in-range ones. Directed cases place the index on the last slot with each generation value, to check that the generation inverts and that the flip flag follows the new generation. They also place an error on a wrapping write, so that an advance on error is told apart from a held descriptor. Indices above the queue length expose missing modulo reduction. A second request held high while a write is pending shows whether busy truly refuses it.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int ENTRY_W  = 32;
  localparam int DATA_W   = ENTRY_W - 1;
  localparam int MIN_LOG2 = 10;
  localparam int BYTES    = ENTRY_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_DONE  = 2'd2
  } evq_state_e;
endpackage

// File: rtl/evq_ptr_advance.sv
module evq_ptr_advance #(
  parameter int IDX_W    = 16,
  parameter int SIZE_W   = 4,
  parameter int MAX_CODE = 6
) (
  input  logic [SIZE_W-1:0] size_code,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic              gen_in,
  input  logic              flip_in,
  output logic [IDX_W-1:0]  idx_cur,
  output logic [IDX_W-1:0]  idx_next,
  output logic              gen_next,
  output logic              flip_next
);
  import evq_pkg::*;

  logic [SIZE_W-1:0] eff_code;
  logic [IDX_W-1:0]  len_mask;
  logic              wrap;

  // Clamp the size code to the largest queue the index width can address.
  assign eff_code = (size_code > SIZE_W'(MAX_CODE)) ? SIZE_W'(MAX_CODE) : size_code;

  always_comb begin
    for (int i = 0; i < IDX_W; i++) begin
      len_mask[i] = (i < (int'(eff_code) + MIN_LOG2));
    end
  end

  assign idx_cur   = idx_in & len_mask;
  assign idx_next  = (idx_cur + IDX_W'(1)) & len_mask;
  assign wrap      = (idx_next == '0);
  assign gen_next  = gen_in ^ wrap;
  assign flip_next = wrap ? gen_next : flip_in;
endmodule

// File: rtl/evq_entry_build.sv
module evq_entry_build #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic [ADDR_W-1:0]           base,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        gen,
  input  logic [evq_pkg::DATA_W-1:0]  data,
  output logic [ADDR_W-1:0]           addr,
  output logic [evq_pkg::ENTRY_W-1:0] word_be
);
  import evq_pkg::*;

  logic [ENTRY_W-1:0] entry;

  assign entry = {gen, data};
  assign addr  = base + (ADDR_W'(idx) << 2);

  // Lowest-address byte lane carries the most significant entry byte.
  for (genvar b = 0; b < BYTES; b++) begin : g_swap
    assign word_be[8*b +: 8] = entry[8*(BYTES-1-b) +: 8];
  end
endmodule

// File: rtl/evq_fsm.sv
module evq_fsm (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic mem_ready,
  output logic load,
  output logic ack,
  output logic busy,
  output logic write_phase,
  output logic done_phase
);
  import evq_pkg::*;

  evq_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (req_valid) state <= ST_WRITE;
        ST_WRITE: if (mem_ready) state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign write_phase = (state == ST_WRITE);
  assign done_phase  = (state == ST_DONE);
  assign load        = (state == ST_IDLE) && req_valid;
  assign ack         = (state == ST_WRITE) && mem_ready;
endmodule

// File: rtl/evq_writer.sv
module evq_writer #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 4,
  parameter int MAX_CODE = 6,
  parameter int IDX_W    = MAX_CODE + 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [evq_pkg::DATA_W-1:0]  req_data,
  input  logic [ADDR_W-1:0]           req_base,
  input  logic [SIZE_W-1:0]           req_size,
  input  logic [IDX_W-1:0]            req_index,
  input  logic                        req_gen,
  input  logic                        req_gen_flip,
  output logic                        busy,
  output logic                        mem_valid,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [evq_pkg::ENTRY_W-1:0] mem_wdata,
  input  logic                        mem_ready,
  input  logic                        mem_err,
  output logic                        upd_valid,
  output logic [IDX_W-1:0]            upd_index,
  output logic                        upd_gen,
  output logic                        upd_gen_flip,
  output logic                        upd_err
);
  import evq_pkg::*;

  logic               load, ack;
  logic [IDX_W-1:0]   idx_cur, idx_next;
  logic               gen_next, flip_next;
  logic [ADDR_W-1:0]  addr_c;
  logic [ENTRY_W-1:0] word_c;

  // Held descriptor results for both outcomes of the write.
  logic [IDX_W-1:0]   hold_idx, adv_idx;
  logic               hold_gen, adv_gen, hold_flip, adv_flip;

  evq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .mem_ready   (mem_ready),
    .load        (load),
    .ack         (ack),
    .busy        (busy),
    .write_phase (mem_valid),
    .done_phase  (upd_valid)
  );

  evq_ptr_advance #(
    .IDX_W    (IDX_W),
    .SIZE_W   (SIZE_W),
    .MAX_CODE (MAX_CODE)
  ) u_ptr (
    .size_code (req_size),
    .idx_in    (req_index),
    .gen_in    (req_gen),
    .flip_in   (req_gen_flip),
    .idx_cur   (idx_cur),
    .idx_next  (idx_next),
    .gen_next  (gen_next),
    .flip_next (flip_next)
  );

  evq_entry_build #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_entry (
    .base    (req_base),
    .idx     (idx_cur),
    .gen     (req_gen),
    .data    (req_data),
    .addr    (addr_c),
    .word_be (word_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      hold_idx  <= '0;
      adv_idx   <= '0;
      hold_gen  <= 1'b0;
      adv_gen   <= 1'b0;
      hold_flip <= 1'b0;
      adv_flip  <= 1'b0;
    end else if (load) begin
      mem_addr  <= addr_c;
      mem_wdata <= word_c;
      hold_idx  <= idx_cur;
      adv_idx   <= idx_next;
      hold_gen  <= req_gen;
      adv_gen   <= gen_next;
      hold_flip <= req_gen_flip;
      adv_flip  <= flip_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_index    <= '0;
      upd_gen      <= 1'b0;
      upd_gen_flip <= 1'b0;
      upd_err      <= 1'b0;
    end else if (ack) begin
      upd_index    <= mem_err ? hold_idx  : adv_idx;
      upd_gen      <= mem_err ? hold_gen  : adv_gen;
      upd_gen_flip <= mem_err ? hold_flip : adv_flip;
      upd_err      <= mem_err;
    end
  end
endmodule

// File: rtl/evq_writer_sva.sv
module evq_writer_sva #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ready,
  input logic              upd_valid,
  input logic [IDX_W-1:0]  upd_index,
  input logic              upd_gen,
  input logic              upd_gen_flip,
  input logic              upd_err
);
  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> mem_valid);

  p_write_busy_r2: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> busy);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

  p_update_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready) |=> upd_valid);

  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> (!upd_valid && !busy));

  p_cause_r7: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> $past(mem_valid && mem_ready));

  p_wrap_flip_r9: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_err && upd_index == '0) |-> (upd_gen_flip == upd_gen));
endmodule

bind evq_writer evq_writer_sva #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W)
) u_sva (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .busy         (busy),
  .mem_valid    (mem_valid),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ready    (mem_ready),
  .upd_valid    (upd_valid),
  .upd_index    (upd_index),
  .upd_gen      (upd_gen),
  .upd_gen_flip (upd_gen_flip),
  .upd_err      (upd_err)
);

// File: tb/evq_writer_tb.sv
module evq_writer_tb;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 4;
  localparam int MAXC   = 6;
  localparam int IDX_W  = MAXC + 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [30:0] req_data = '0;
  logic [ADDR_W-1:0] req_base = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic [IDX_W-1:0] req_index = '0;
  logic req_gen = 1'b0, req_gen_flip = 1'b0;
  logic busy, mem_valid, mem_ready = 1'b0, mem_err = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic upd_valid, upd_gen, upd_gen_flip, upd_err;
  logic [IDX_W-1:0] upd_index;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  evq_writer #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_CODE(MAXC), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_data(req_data), .req_base(req_base),
    .req_size(req_size), .req_index(req_index), .req_gen(req_gen), .req_gen_flip(req_gen_flip),
    .busy(busy), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_err(mem_err), .upd_valid(upd_valid), .upd_index(upd_index),
    .upd_gen(upd_gen), .upd_gen_flip(upd_gen_flip), .upd_err(upd_err));

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int entries_of(int code);
    int c = (code > MAXC) ? MAXC : code;
    return 1 << (c + 10);
  endfunction

  function automatic logic [31:0] exp_word(logic g, logic [30:0] d);
    logic [31:0] e = {g, d};
    return {e[7:0], e[15:8], e[23:16], e[31:24]};
  endfunction

  // One complete enqueue; starts and ends at a falling edge with the block idle.
  task automatic enqueue(logic [30:0] d, logic [31:0] base, int code, int idx,
                         logic g, logic f, int delay, logic err, bit intrude);
    int n  = entries_of(code);
    int mi = idx & (n - 1);
    int nx = (mi + 1) & (n - 1);
    logic [31:0] ea = base + 32'(mi * 4);
    logic [31:0] ew = exp_word(g, d);
    logic eg, ef;
    int ei;
    if (err) begin ei = mi; eg = g; ef = f; end
    else if (nx == 0) begin ei = 0; eg = ~g; ef = ~g; end
    else begin ei = nx; eg = g; ef = f; end
    req_data = d; req_base = base; req_size = SIZE_W'(code);
    req_index = IDX_W'(idx); req_gen = g; req_gen_flip = f; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    req_data = ~d; req_base = ~base; req_index = ~IDX_W'(idx); req_gen = ~g;
    check("R2", "busy", busy, 1);
    check("R2", "mem_valid", mem_valid, 1);
    check("R3", "mem_addr", mem_addr, ea);
    check("R4", "mem_wdata", mem_wdata, ew);
    for (int k = 0; k < delay; k++) begin
      req_valid = intrude;
      @(posedge clk); @(negedge clk);
      check("R6", "mem_valid held", mem_valid, 1);
      check("R6", "mem_addr held", mem_addr, ea);
      check("R6", "mem_wdata held", mem_wdata, ew);
      check("R7", "no early update", upd_valid, 0);
    end
    req_valid = intrude;
    mem_ready = 1'b1; mem_err = err;
    @(posedge clk); @(negedge clk);
    mem_ready = 1'b0; mem_err = 1'b0; req_valid = 1'b0;
    check("R7", "upd_valid", upd_valid, 1);
    check("R7", "mem_valid dropped", mem_valid, 0);
    check(err ? "R10" : (nx == 0 ? "R9" : "R8"), "upd_index", upd_index, ei);
    check(err ? "R10" : (nx == 0 ? "R9" : "R8"), "upd_gen", upd_gen, eg);
    check(err ? "R10" : (nx == 0 ? "R9" : "R8"), "upd_gen_flip", upd_gen_flip, ef);
    check("R10", "upd_err", upd_err, err);
    @(posedge clk); @(negedge clk);
    check("R7", "single update", upd_valid, 0);
    check("R7", "busy released", busy, 0);
    check("R2", "refused request wrote nothing", mem_valid, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check("R1", "busy in reset", busy, 0);
    check("R1", "mem_valid in reset", mem_valid, 0);
    check("R1", "upd_valid in reset", upd_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "busy after reset", busy, 0);
    check("R1", "upd_valid after reset", upd_valid, 0);

    // Directed corners.
    enqueue(31'h1234567, 32'h1000_0000, 0, 5, 1'b0, 1'b0, 0, 1'b0, 0);       // R8 mid-queue
    enqueue(31'h7fffffff, 32'h2000_0000, 0, 1023, 1'b0, 1'b0, 1, 1'b0, 1);   // R9 wrap gen 0 -> 1
    enqueue(31'h0, 32'h2000_0000, 0, 1023, 1'b1, 1'b1, 2, 1'b0, 0);          // R9 wrap gen 1 -> 0
    enqueue(31'h55aa55a, 32'h3000_0000, 0, 1023, 1'b1, 1'b0, 0, 1'b1, 0);    // R10 error at wrap
    enqueue(31'h0abcdef, 32'h4000_0000, 0, 2000, 1'b0, 1'b1, 0, 1'b0, 0);    // R5 index above length
    enqueue(31'h1111111, 32'h5000_0000, 15, 65535, 1'b0, 1'b0, 0, 1'b0, 0);  // R5 clamped code wraps
    enqueue(31'h2222222, 32'h5000_0000, 15, 1023, 1'b0, 1'b0, 0, 1'b0, 0);   // R5 clamped code no wrap
    enqueue(31'h3333333, 32'hffff_fffc, 6, 3, 1'b1, 1'b0, 3, 1'b0, 1);       // R3 address wraps

    // Random mix.
    for (int t = 0; t < 300; t++) begin
      int code = $urandom_range(0, 15);
      int n = entries_of(code);
      int idx = ($urandom_range(0, 3) == 0) ? (n - 1) : int'($urandom_range(0, 65535));
      enqueue(31'($urandom), $urandom, code, idx, 1'($urandom), 1'($urandom),
              $urandom_range(0, 3), ($urandom_range(0, 7) == 0), 1'($urandom));
    end
    finished = 1;
    summary();
  end
endmodule